// File: doc/BRIEF.md
# Array Cell Unsigned Multiplier

This block multiplies two unsigned operands of N bits each and returns a 2N-bit product. It has no clock and no state. The default width is N = 4, which gives an 8-bit result. The product is built from a square grid of identical cells, and no multiply operator is used.

Each cell in the grid does two things:
- It forms one partial product, the AND of one multiplicand bit and one multiplier bit.
- It adds that term to a sum coming from the cell above it and to a carry coming from its diagonal neighbour.

The first row holds only AND terms and has no adders. Every later row adds the next multiplier bit's partial products to the running total. Carries ripple along each row.

The result leaves the block as two N-bit halves, one for the low-order bits and one for the high-order bits. Each half has its own pair of active-low enables. A half drives its bits only while both of its enables are low; at all other times it floats at high impedance. Because each half is controlled separately, the two halves can share a narrow bus.

Top module: `arr_mult`

## Requirements
- R1: For every pair of operands, the concatenation {prod_hi_o, prod_lo_o} equals the unsigned arithmetic product mcand_i × mplier_i. Product bits N-1..0 appear on prod_lo_o and bits 2N-1..N on prod_hi_o, whenever both halves are enabled.
- R2: Product bit 0 (prod_lo_o[0]) equals mcand_i[0] AND mplier_i[0].
- R3: Product bit 1 (prod_lo_o[1]) equals the exclusive OR of (mcand_i[1] AND mplier_i[0]) and (mcand_i[0] AND mplier_i[1]).
- R4: When either operand is zero, both halves of the product are zero.
- R5: When one operand is 1, the product equals the other operand, and the high half is zero.
- R6: With both operands at their maximum value (15 × 15 for N = 4), the product is 225. The high half reads 4'hE and the low half reads 4'h1.
- R7: prod_lo_o is driven only while lo_oe0_n and lo_oe1_n are both 0. For the other three enable combinations, every bit of prod_lo_o is high impedance. This holds whatever the high half's enables are.
- R8: prod_hi_o is driven only while hi_oe0_n and hi_oe1_n are both 0. For the other three enable combinations, every bit of prod_hi_o is high impedance. This holds whatever the low half's enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Unsigned multiplicand |
| mplier_i | input | N | Unsigned multiplier |
| lo_oe0_n | input | 1 | First active-low enable of the low half |
| lo_oe1_n | input | 1 | Second active-low enable of the low half |
| hi_oe0_n | input | 1 | First active-low enable of the high half |
| hi_oe1_n | input | 1 | Second active-low enable of the high half |
| prod_lo_o | output | N | Low-order product bits, high impedance when disabled |
| prod_hi_o | output | N | High-order product bits, high impedance when disabled |

## Verification
The bench applies all 256 operand pairs. This exposes any miswired diagonal carry or row offset, since such a fault corrupts only the columns that depend on that cell. The directed cases 15 × 15, 8 × 8, zero and one test the longest carry chain and the weight alignment of each row; an adder that dropped its final carry would report 15 × 15 as 0x61 instead of 0xE1. The bench reads every half through two copies of the block, one on pulldown nets and one on pullup nets. A half that drove when it should float, or that followed the other half's enables, then shows as a mismatch between the two copies.

// File: rtl/arr_mult_pkg.sv
package arr_mult_pkg;
  // Default operand width shared by the array, checker and bench
  localparam int unsigned OPW_DEF = 4;

  // Width of the full product for an operand width
  function automatic int unsigned prod_width(input int unsigned opw);
    return 2 * opw;
  endfunction
endpackage

// File: rtl/full_add.sv
module full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic xy_p;

  assign xy_p = x_i ^ y_i;
  assign s_o  = xy_p ^ ci_i;
  assign co_o = (x_i & y_i) | (xy_p & ci_i);
endmodule

// File: rtl/mul_cell.sv
module mul_cell (
  input  logic a_bit_i,
  input  logic b_bit_i,
  input  logic sum_in_i,
  input  logic carry_in_i,
  output logic sum_out_o,
  output logic carry_out_o
);
  logic pp;

  // local partial product
  assign pp = a_bit_i & b_bit_i;

  full_add u_fa (
    .x_i  (pp),
    .y_i  (sum_in_i),
    .ci_i (carry_in_i),
    .s_o  (sum_out_o),
    .co_o (carry_out_o)
  );
endmodule

// File: rtl/mul_array.sv
module mul_array #(
  parameter int unsigned OPW = arr_mult_pkg::OPW_DEF,
  localparam int unsigned PW = arr_mult_pkg::prod_width(OPW)
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PW-1:0]  p_o
);
  // Row r holds OPW sum bits plus the row's final carry in bit OPW.
  // Bit 0 of each row is final product bit r; bits above it feed the next row.
  logic [OPW-1:0][OPW:0]   row_sum;
  logic [OPW-1:1][OPW-1:0] row_car;

  // Top row: AND terms only, no adders
  for (genvar i = 0; i < OPW; i++) begin : g_top
    assign row_sum[0][i] = a_i[i] & b_i[0];
  end
  assign row_sum[0][OPW] = 1'b0;
  assign p_o[0]          = row_sum[0][0];

  for (genvar r = 1; r < OPW; r++) begin : g_row
    for (genvar i = 0; i < OPW; i++) begin : g_col
      logic cin;
      if (i == 0) begin : g_first
        // half-adder position: carry input tied low
        assign cin = 1'b0;
      end else begin : g_rest
        // carry from the neighbouring cell, diagonal in the skewed grid
        assign cin = row_car[r][i-1];
      end

      mul_cell u_cell (
        .a_bit_i     (a_i[i]),
        .b_bit_i     (b_i[r]),
        .sum_in_i    (row_sum[r-1][i+1]),
        .carry_in_i  (cin),
        .sum_out_o   (row_sum[r][i]),
        .carry_out_o (row_car[r][i])
      );
    end
    assign row_sum[r][OPW] = row_car[r][OPW-1];
    assign p_o[r]          = row_sum[r][0];
  end

  // Remaining upper product bits come from the last row
  for (genvar k = 1; k <= OPW; k++) begin : g_upper
    assign p_o[OPW-1+k] = row_sum[OPW-1][k];
  end
endmodule

// File: rtl/half_drv.sv
module half_drv #(
  parameter int unsigned W = arr_mult_pkg::OPW_DEF
) (
  input  logic [W-1:0] val_i,
  input  logic         en0_n,
  input  logic         en1_n,
  output wire  [W-1:0] q_o
);
  logic drive;

  assign drive = ~en0_n & ~en1_n;
  assign q_o   = drive ? val_i : {W{1'bz}};
endmodule

// File: rtl/arr_mult.sv
module arr_mult #(
  parameter int unsigned OPW = arr_mult_pkg::OPW_DEF,
  localparam int unsigned PW = arr_mult_pkg::prod_width(OPW)
) (
  input  logic [OPW-1:0] mcand_i,
  input  logic [OPW-1:0] mplier_i,
  input  logic           lo_oe0_n,
  input  logic           lo_oe1_n,
  input  logic           hi_oe0_n,
  input  logic           hi_oe1_n,
  output wire  [OPW-1:0] prod_lo_o,
  output wire  [OPW-1:0] prod_hi_o
);
  logic [PW-1:0] prod_w;

  mul_array #(.OPW(OPW)) u_array (
    .a_i (mcand_i),
    .b_i (mplier_i),
    .p_o (prod_w)
  );

  half_drv #(.W(OPW)) u_lo (
    .val_i (prod_w[OPW-1:0]),
    .en0_n (lo_oe0_n),
    .en1_n (lo_oe1_n),
    .q_o   (prod_lo_o)
  );

  half_drv #(.W(OPW)) u_hi (
    .val_i (prod_w[PW-1:OPW]),
    .en0_n (hi_oe0_n),
    .en1_n (hi_oe1_n),
    .q_o   (prod_hi_o)
  );
endmodule

// File: rtl/arr_mult_chk.sv
module arr_mult_chk #(
  parameter int unsigned OPW = arr_mult_pkg::OPW_DEF,
  localparam int unsigned PW = arr_mult_pkg::prod_width(OPW)
) (
  input logic [OPW-1:0] a,
  input logic [OPW-1:0] b,
  input logic [PW-1:0]  prod
);
  logic [PW-1:0] ref_p;

  assign ref_p = PW'(a) * PW'(b);

  always_comb begin
    // R1
    prod_value_chk: assert (prod == ref_p) else $error("array product mismatch");
    // R2
    bit0_chk: assert (prod[0] == (a[0] & b[0])) else $error("bit 0 wrong");
    // R3
    bit1_chk: assert (prod[1] == ((a[1] & b[0]) ^ (a[0] & b[1]))) else $error("bit 1 wrong");
    // R4
    if (a == '0 || b == '0) begin
      zero_op_chk: assert (prod == '0) else $error("zero operand gave nonzero");
    end
    // R5
    if (b == OPW'(1)) begin
      unit_op_chk: assert (prod == PW'(a)) else $error("unit multiplier wrong");
    end
  end
endmodule

bind arr_mult arr_mult_chk #(.OPW(OPW)) u_chk (
  .a    (mcand_i),
  .b    (mplier_i),
  .prod (prod_w)
);

// File: tb/arr_mult_tb.sv
module arr_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic [3:0] a = '0, b = '0;
  logic       lo0 = 1'b1, lo1 = 1'b1, hi0 = 1'b1, hi1 = 1'b1;
  wire  [3:0] lo_pd, hi_pd, lo_pu, hi_pu;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pulldown copy reads 0 and pullup copy reads 1 on a floating bit
  for (genvar k = 0; k < 4; k++) begin : g_pull
    pulldown (lo_pd[k]);
    pulldown (hi_pd[k]);
    pullup   (lo_pu[k]);
    pullup   (hi_pu[k]);
  end

  arr_mult u_dut (
    .mcand_i (a), .mplier_i (b),
    .lo_oe0_n (lo0), .lo_oe1_n (lo1), .hi_oe0_n (hi0), .hi_oe1_n (hi1),
    .prod_lo_o (lo_pd), .prod_hi_o (hi_pd)
  );

  arr_mult u_dut_pu (
    .mcand_i (a), .mplier_i (b),
    .lo_oe0_n (lo0), .lo_oe1_n (lo1), .hi_oe0_n (hi0), .hi_oe1_n (hi1),
    .prod_lo_o (lo_pu), .prod_hi_o (hi_pu)
  );

  function automatic logic [7:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
    return 8'(x) * 8'(y);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%0d b=%0d)", req, act, exp, a, b);
    end
  endtask

  // one half: driven value on both copies, or floating (0 on pulldown, F on pullup)
  task automatic check_half(input string req, input logic e0, input logic e1,
                            input logic [3:0] pd, input logic [3:0] pu,
                            input logic [3:0] exp);
    if (!e0 && !e1) check(req, {pd, pu}, {exp, exp});
    else            check(req, {pd, pu}, {4'h0, 4'hF});
  endtask

  task automatic apply(input logic [3:0] x, input logic [3:0] y, input logic [3:0] en);
    @(negedge clk);
    a = x; b = y; {lo0, lo1, hi0, hi1} = en;
    #1;
  endtask

  initial begin
    logic [7:0] p;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);

    // idle state: all enables high, both halves float (R7, R8)
    #1;
    check_half("R7 idle", lo0, lo1, lo_pd, lo_pu, 4'h0);
    check_half("R8 idle", hi0, hi1, hi_pd, hi_pu, 4'h0);

    // exhaustive operand sweep with both halves on
    for (int i = 0; i < 256; i++) begin
      apply(4'(i >> 4), 4'(i), 4'b0000);
      p = ref_mul(a, b);
      check("R1", {hi_pd, lo_pd}, p);
      check("R2", {7'd0, lo_pd[0]}, {7'd0, a[0] & b[0]});
      check("R3", {7'd0, lo_pd[1]}, {7'd0, (a[1] & b[0]) ^ (a[0] & b[1])});
    end

    // directed corners
    apply(4'd0, 4'd13, 4'b0000);  check("R4 a=0", {hi_pd, lo_pd}, 8'h00);
    apply(4'd11, 4'd0, 4'b0000);  check("R4 b=0", {hi_pd, lo_pd}, 8'h00);
    apply(4'd13, 4'd1, 4'b0000);  check("R5 b=1", {hi_pd, lo_pd}, 8'h0D);
    apply(4'd1, 4'd9, 4'b0000);   check("R5 a=1", {hi_pd, lo_pd}, 8'h09);
    apply(4'd15, 4'd15, 4'b0000);
    check("R6 hi", {4'h0, hi_pd}, 8'h0E);
    check("R6 lo", {4'h0, lo_pd}, 8'h01);
    apply(4'd8, 4'd8, 4'b0000);   check("R1 8x8", {hi_pd, lo_pd}, 8'h40);
    apply(4'd13, 4'd11, 4'b0000); check("R1 13x11", {hi_pd, lo_pd}, 8'h8F);

    // every enable combination on a fixed product 0xE1
    for (int e = 0; e < 16; e++) begin
      apply(4'd15, 4'd15, 4'(e));
      check_half("R7 sweep", lo0, lo1, lo_pd, lo_pu, 4'h1);
      check_half("R8 sweep", hi0, hi1, hi_pd, hi_pu, 4'hE);
    end

    // random operands and enables
    for (int n = 0; n < 400; n++) begin
      apply(4'($urandom), 4'($urandom), 4'($urandom));
      p = ref_mul(a, b);
      check_half("R7 rand", lo0, lo1, lo_pd, lo_pu, p[3:0]);
      check_half("R8 rand", hi0, hi1, hi_pd, hi_pu, p[7:4]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule